// File: doc/BRIEF.md
# DMA Channel Transfer Counter with Auto-Reload

This block keeps the transfer bookkeeping for one DMA channel. Software-side logic programs a base offset, a base count (the number of bytes minus one) and a page. A load strobe then copies these into the working registers. The working registers are a 24-bit linear address (page in bits 23:16 above a 16-bit offset), a 17-bit remaining count, and a 16-bit current offset.

A client asks for a burst of N bytes. The block answers with the number of bytes it grants. It then emits that many linear addresses, one per valid/ready handshake, and steps its working registers on each one. After the last address it pulses a done strobe.

When a burst reaches terminal count (the remaining count reaches zero), the result depends on the mode. In one-shot mode the grant is cut to what was left and the channel's terminal-count status bit is set. In auto-reload mode the working registers are reloaded from the base values, and the rest of the burst continues from the base address.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset, `cur_cnt` is 0, `cur_addr` is 0, `status` is all zeros, `addr_valid`, `grant_valid` and `done` are 0, and `req_ready` is 1.
- R2: A `cfg_load` pulse while idle (`req_ready`=1) sets the linear address to `cfg_page`*65536 + `cfg_base_addr`, `cur_cnt` to `cfg_base_cnt`+1 and `cur_addr` to `cfg_base_addr`. A `cfg_load` pulse while a burst is in progress has no effect.
- R3: A request whose length is below `cur_cnt` is granted in full. After the burst, `cur_addr` has advanced by the length and `cur_cnt` has dropped by it.
- R4: In one-shot mode (`cfg_autoinit`=0), a request whose length is equal to or above a non-zero `cur_cnt` is granted exactly `cur_cnt` bytes. After the burst `cur_cnt` is 0 and `cur_addr` has advanced by the grant.
- R5: In one-shot mode, the address that brings `cur_cnt` to zero sets `status` bit `CHAN_IDX`. Reaching zero in auto-reload mode leaves `status` unchanged.
- R6: In auto-reload mode (`cfg_autoinit`=1, sampled when the request is accepted), the grant equals the request length. The address that brings `cur_cnt` to zero reloads the working registers from the base values. The remaining addresses continue from page*65536 + base offset, and the count drops by one for each of them.
- R7: Each accepted handshake (`addr_valid` and `addr_ready` both high) consumes one address. The addresses are the linear address at that moment, rising by one per beat (carrying into the page field) until a reload. While `addr_ready` is low, `addr_out` holds steady and `addr_valid` stays high.
- R8: `grant_valid` pulses for one cycle, in the cycle after a request is accepted, carrying `grant_len`. `done` pulses one cycle after the last address is consumed. `req_ready` is low from acceptance until that `done` pulse.
- R9: A request made while `cur_cnt` is 0 is granted 0 bytes, emits no address, and is followed by `done` in the next cycle.
- R10: A `stat_rd` pulse clears `status`. If a terminal-count set falls in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base_addr | input | 16 | Base offset |
| cfg_base_cnt | input | 16 | Base count (bytes minus one) |
| cfg_page | input | 8 | Page, linear address bits 23:16 |
| cfg_autoinit | input | 1 | 1 = auto-reload mode, 0 = one-shot mode |
| cfg_load | input | 1 | Load working registers from the base values (idle only) |
| req_valid | input | 1 | Burst request strobe |
| req_len | input | 16 | Requested byte count |
| req_ready | output | 1 | Idle, request accepted |
| grant_valid | output | 1 | Grant result strobe |
| grant_len | output | 16 | Bytes granted |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer takes the address |
| addr_out | output | 24 | Linear address |
| done | output | 1 | Burst complete pulse |
| cur_cnt | output | 17 | Remaining count |
| cur_addr | output | 16 | Current offset |
| stat_rd | input | 1 | Status read, clears terminal-count bits |
| status | output | NUM_CHAN | Terminal-count status bits |

## Verification
The hardest case to reach is an auto-reload burst that crosses terminal count while the consumer stalls. The crossing beat must then take the reload path and not the plain step, and the remaining addresses must start again at the base address. The stimulus first loads a short count and spends part of it with a small request. It then issues a request larger than what is left, with `addr_ready` driven by a pseudo-random pattern, so that the reload beat can land on a stalled cycle. A `cfg_load` pulse asserted in the middle of a one-shot burst then checks that a reload is refused while busy.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  localparam int OFS_W  = 16;
  localparam int PAGE_W = 8;
  localparam int LIN_W  = OFS_W + PAGE_W;
  localparam int CNT_W  = OFS_W + 1;
  localparam int LEN_W  = OFS_W;

  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [LIN_W-1:0]  lin_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [LEN_W-1:0]  len_t;

  // bytes granted for a request of len against remaining count cnt
  function automatic len_t grant_of(input len_t len, input cnt_t cnt, input logic ai);
    if (cnt == '0)                      return '0;
    if (ai || (cnt_t'(len) < cnt))      return len;
    return len_t'(cnt);
  endfunction

  function automatic lin_t lin_of(input page_t page, input ofs_t base);
    return (lin_t'(page) << OFS_W) + lin_t'(base);
  endfunction

  function automatic cnt_t reload_cnt(input ofs_t base_cnt);
    return cnt_t'(base_cnt) + cnt_t'(1);
  endfunction
endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  len_t req_len,
  input  cnt_t cur_cnt,
  input  logic cfg_autoinit,
  input  logic beat,
  output logic req_ready,
  output logic busy,
  output logic remain_nz,
  output logic grant_valid,
  output len_t grant_len,
  output logic done,
  output logic ai_mode
);
  len_t remain_q;
  logic accept, finish;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign remain_nz = (remain_q != '0);
  assign finish    = busy && (!remain_nz || (beat && remain_q == len_t'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      remain_q    <= '0;
      grant_valid <= 1'b0;
      grant_len   <= '0;
      done        <= 1'b0;
      ai_mode     <= 1'b0;
    end else begin
      grant_valid <= accept;
      done        <= finish;
      if (accept) begin
        busy      <= 1'b1;
        remain_q  <= grant_of(req_len, cur_cnt, cfg_autoinit);
        grant_len <= grant_of(req_len, cur_cnt, cfg_autoinit);
        ai_mode   <= cfg_autoinit;
      end else begin
        if (beat) remain_q <= remain_q - len_t'(1);
        if (finish) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_xfer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_cfg,
  input  logic  beat,
  input  logic  ai_mode,
  input  ofs_t  cfg_base_addr,
  input  ofs_t  cfg_base_cnt,
  input  page_t cfg_page,
  output lin_t  lin_addr,
  output cnt_t  cur_cnt,
  output ofs_t  cur_addr,
  output logic  tc_hit,
  output logic  wrap_reload
);
  assign tc_hit      = beat && (cur_cnt == cnt_t'(1));
  assign wrap_reload = tc_hit && ai_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_addr <= '0;
      cur_cnt  <= '0;
      cur_addr <= '0;
    end else if (load_cfg || wrap_reload) begin
      lin_addr <= lin_of(cfg_page, cfg_base_addr);
      cur_cnt  <= reload_cnt(cfg_base_cnt);
      cur_addr <= cfg_base_addr;
    end else if (beat) begin
      lin_addr <= lin_addr + lin_t'(1);
      cur_cnt  <= cur_cnt - cnt_t'(1);
      cur_addr <= cur_addr + ofs_t'(1);
    end
  end
endmodule

// File: rtl/dma_tc_status.sv
module dma_tc_status #(
  parameter int NUM_CHAN = 4,
  parameter int CHAN_IDX = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tc_set,
  input  logic                stat_rd,
  output logic [NUM_CHAN-1:0] status
);
  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_bit
    if (i == CHAN_IDX) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       status[i] <= 1'b0;
        else if (tc_set)  status[i] <= 1'b1;
        else if (stat_rd) status[i] <= 1'b0;
      end
    end else begin : g_tie
      assign status[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import dma_xfer_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int CHAN_IDX = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         cfg_base_addr,
  input  logic [15:0]         cfg_base_cnt,
  input  logic [7:0]          cfg_page,
  input  logic                cfg_autoinit,
  input  logic                cfg_load,
  input  logic                req_valid,
  input  logic [15:0]         req_len,
  output logic                req_ready,
  output logic                grant_valid,
  output logic [15:0]         grant_len,
  output logic                addr_valid,
  input  logic                addr_ready,
  output logic [23:0]         addr_out,
  output logic                done,
  output logic [16:0]         cur_cnt,
  output logic [15:0]         cur_addr,
  input  logic                stat_rd,
  output logic [NUM_CHAN-1:0] status
);
  logic busy, remain_nz, ai_mode, beat, tc_hit, wrap_reload, tc_set, load_cfg;

  assign addr_valid = busy && remain_nz;
  assign beat       = addr_valid && addr_ready;
  assign load_cfg   = cfg_load && !busy;
  assign tc_set     = tc_hit && !ai_mode;

  dma_req_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .cur_cnt(cur_cnt), .cfg_autoinit(cfg_autoinit), .beat(beat),
    .req_ready(req_ready), .busy(busy), .remain_nz(remain_nz),
    .grant_valid(grant_valid), .grant_len(grant_len), .done(done), .ai_mode(ai_mode)
  );

  dma_chan_regs u_regs (
    .clk(clk), .rst_n(rst_n), .load_cfg(load_cfg), .beat(beat), .ai_mode(ai_mode),
    .cfg_base_addr(cfg_base_addr), .cfg_base_cnt(cfg_base_cnt), .cfg_page(cfg_page),
    .lin_addr(addr_out), .cur_cnt(cur_cnt), .cur_addr(cur_addr),
    .tc_hit(tc_hit), .wrap_reload(wrap_reload)
  );

  dma_tc_status #(.NUM_CHAN(NUM_CHAN), .CHAN_IDX(CHAN_IDX)) u_stat (
    .clk(clk), .rst_n(rst_n), .tc_set(tc_set), .stat_rd(stat_rd), .status(status)
  );
endmodule

// File: rtl/dma_xfer_counter_chk.sv
module dma_xfer_counter_chk #(
  parameter int NUM_CHAN = 4,
  parameter int CHAN_IDX = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                grant_valid,
  input logic [15:0]         grant_len,
  input logic                addr_valid,
  input logic                addr_ready,
  input logic [23:0]         addr_out,
  input logic [16:0]         cur_cnt,
  input logic [15:0]         cfg_base_cnt,
  input logic                ai_mode,
  input logic                stat_rd,
  input logic                tc_set,
  input logic [NUM_CHAN-1:0] status
);
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

  assert_grant_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> grant_valid);

  assert_busy_on_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !req_ready);

  assert_zero_grant_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_len == 16'd0) |-> !addr_valid);

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && cur_cnt != 17'd1) |=> (cur_cnt == $past(cur_cnt) - 17'd1));

  assert_oneshot_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && cur_cnt == 17'd1 && !ai_mode)
      |=> (cur_cnt == 17'd0 && status[CHAN_IDX]));

  assert_autoreload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && cur_cnt == 17'd1 && ai_mode)
      |=> (cur_cnt == {1'b0, $past(cfg_base_cnt)} + 17'd1));

  assert_stat_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tc_set) |=> (status == '0));
endmodule

bind dma_xfer_counter dma_xfer_counter_chk #(.NUM_CHAN(NUM_CHAN), .CHAN_IDX(CHAN_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .grant_valid(grant_valid), .grant_len(grant_len), .addr_valid(addr_valid),
  .addr_ready(addr_ready), .addr_out(addr_out), .cur_cnt(cur_cnt),
  .cfg_base_cnt(cfg_base_cnt), .ai_mode(ai_mode), .stat_rd(stat_rd),
  .tc_set(tc_set), .status(status)
);

// File: tb/dma_xfer_counter_tb.sv
module dma_xfer_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CIDX = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_base_addr = '0, cfg_base_cnt = '0, req_len = '0;
  logic [7:0]  cfg_page = '0;
  logic cfg_autoinit = 1'b0, cfg_load = 1'b0, req_valid = 1'b0, stat_rd = 1'b0;
  logic req_ready, grant_valid, addr_valid, done, addr_ready;
  logic [15:0] grant_len, cur_addr;
  logic [23:0] addr_out;
  logic [16:0] cur_cnt;
  logic [NCH-1:0] status;

  logic stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  int checks = 0, errors = 0, cycles = 0;

  // bench model
  logic [23:0] m_lin = '0;
  logic [16:0] m_cnt = '0;
  logic [15:0] m_cur = '0;
  logic        m_stat = 1'b0;
  logic [23:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7]^lfsr[5]^lfsr[4]^lfsr[3]};
  assign addr_ready = stall_en ? lfsr[0] : 1'b1;

  dma_xfer_counter #(.NUM_CHAN(NCH), .CHAN_IDX(CIDX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base_addr(cfg_base_addr), .cfg_base_cnt(cfg_base_cnt),
    .cfg_page(cfg_page), .cfg_autoinit(cfg_autoinit), .cfg_load(cfg_load),
    .req_valid(req_valid), .req_len(req_len), .req_ready(req_ready),
    .grant_valid(grant_valid), .grant_len(grant_len), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_out(addr_out), .done(done), .cur_cnt(cur_cnt),
    .cur_addr(cur_addr), .stat_rd(stat_rd), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected addresses as beats occur
  always @(negedge clk) begin
    cycles++;
    if (rst_n && addr_valid && addr_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected address", addr_out, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk(addr_out == e, "R7/R6 address", addr_out, e);
      end
    end
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic model_load();
    m_lin = {cfg_page, 16'h0} + {8'h0, cfg_base_addr};
    m_cnt = {1'b0, cfg_base_cnt} + 17'd1;
    m_cur = cfg_base_addr;
  endtask

  task automatic do_load(input logic [15:0] base, input logic [15:0] bc, input logic [7:0] pg);
    @(negedge clk);
    cfg_base_addr = base; cfg_base_cnt = bc; cfg_page = pg; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    model_load();
    chk(cur_cnt == m_cnt, "R2 load count", cur_cnt, m_cnt);
    chk(cur_addr == m_cur, "R2 load offset", cur_addr, m_cur);
  endtask

  task automatic do_req(input logic [15:0] len, input bit poke_load, input string tag);
    logic [15:0] g;
    int n;
    while (!req_ready) @(negedge clk);
    if (m_cnt == 0) g = 0;
    else if (cfg_autoinit || {1'b0, len} < m_cnt) g = len;
    else g = m_cnt[15:0];
    for (int i = 0; i < g; i++) begin
      exp_q.push_back(m_lin);
      m_lin++; m_cnt--; m_cur++;
      if (m_cnt == 0) begin
        if (cfg_autoinit) model_load(); else m_stat = 1'b1;
      end
    end
    req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(grant_valid && grant_len == g, {tag, " grant"}, grant_len, g);
    chk(!req_ready || g == 0, "R8 busy", req_ready, 0);
    if (poke_load) begin
      cfg_base_addr = 16'h7777; cfg_base_cnt = 16'h0005; cfg_load = 1'b1;
    end
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    cfg_load = 1'b0;
    chk(done, "R8 done pulse", done, 1);
    chk(exp_q.size() == 0, "R7 addresses left", exp_q.size(), 0);
    chk(cur_cnt == m_cnt, {tag, " count"}, cur_cnt, m_cnt);
    chk(cur_addr == m_cur, {tag, " offset"}, cur_addr, m_cur);
    chk(status[CIDX] == m_stat, "R5 status", status, m_stat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cur_cnt == 0 && cur_addr == 0, "R1 regs", cur_cnt, 0);
    chk(status == 0 && !addr_valid && !grant_valid && !done, "R1 outputs", status, 0);
    chk(req_ready, "R1 ready", req_ready, 1);

    // one-shot mode
    cfg_autoinit = 1'b0;
    do_load(16'h1000, 16'd9, 8'h12);                 // R2
    do_req(16'd4, 1'b0, "R3");                        // partial
    do_req(16'd8, 1'b0, "R4");                        // truncated to 6, R5 set
    do_req(16'd5, 1'b0, "R9");                        // count zero -> grant 0
    // R10 status read clears
    @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; m_stat = 1'b0;
    chk(status == 0, "R10 clear", status, 0);

    // R2: load ignored while busy, one-shot exact hit with stalls
    do_load(16'hFFFE, 16'd5, 8'h03);                  // page carry across offset wrap
    stall_en = 1'b1;
    do_req(16'd6, 1'b1, "R2 busy-load/R4");
    stall_en = 1'b0;
    @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; m_stat = 1'b0;

    // auto-reload mode
    cfg_autoinit = 1'b1;
    do_load(16'h2000, 16'd9, 8'h40);
    do_req(16'd7, 1'b0, "R3 ai");
    stall_en = 1'b1;
    do_req(16'd8, 1'b0, "R6 cross");                  // 3 then reload, 5 leftover
    do_req(16'd5, 1'b0, "R6 exact");                  // lands exactly on reload
    stall_en = 1'b0;
    do_req(16'd3, 1'b0, "R6 after");
    chk(status == 0, "R5 ai no status", status, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule